// File: doc/BRIEF.md
# UART Baud Tick Generator with Receive Resynchronisation

This block produces the two bit-rate strobes a UART needs: one for the transmitter and one for the receiver. Both come from one 8-bit auto-reload timing scheme that software sets with a single reload byte. A free-running transmit counter and a separate receive counter both count up from that byte. Each wraps after (256 − reload) input ticks. Each wrap toggles a divide-by-two stage, and every second wrap produces a one-cycle baud tick. The bit rate is therefore the input tick rate divided by 2·(256 − reload).

The input tick comes from one of six sources:
- the system clock,
- the system clock divided by 4, 12 or 48,
- an asynchronous oscillator input divided by 8,
- an asynchronous external pin.

All logic runs on the single system clock. The prescaled and external sources become one-cycle enable pulses, so no derived clocks exist. The block also watches the receive line. It synchronises the line and detects a falling edge while the receiver reports that it is idle. On that event it reloads the receive counter and clears the receive divider. The receive bit timing then starts at a fixed point relative to the start bit, whatever the transmit counter is doing.

Top module: `baud_gen_resync`

## Requirements
- R1: With source 0 (system clock) and enable high, `tx_tick_o` pulses for one cycle exactly every 2·(256 − `reload_i`) clock cycles.
- R2: At the reload extremes the period is 2 cycles for reload 0xFF and 512 cycles for reload 0x00.
- R3: When `rxd_i` falls while `rx_idle_i` is high, with source 0 and reload R, the first `rx_tick_o` pulse comes 2·(256 − R) + 2 rising edges after the first edge that samples `rxd_i` low. Further pulses follow every 2·(256 − R) cycles.
- R4: A start-bit resynchronisation does not disturb `tx_tick_o`, whose spacing stays 2·(256 − R).
- R5: Source select values 1, 2 and 3 divide the input tick rate by 4, 12 and 48 respectively. The tick period becomes 2·(256 − R)·divisor cycles.
- R6: With source 5, each rising edge of `ext_pin_i` is one input tick.
- R7: With source 4, every eighth rising edge of `ext_osc_i` is one input tick.
- R8: While `en_i` is low, both counters and both divider stages hold their state. The next tick after re-enabling is delayed by exactly the number of disabled cycles.
- R9: A falling edge on `rxd_i` while `rx_idle_i` is low causes no resynchronisation, so the receive ticks stay coincident with the transmit ticks.
- R10: During reset both ticks are low. After reset, both counters start from the reload value with cleared dividers. The first ticks of both channels therefore appear together, 2·(256 − R) cycles after the last reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Timer run enable |
| reload_i | input | 8 | Shared reload byte |
| src_sel_i | input | 3 | Tick source: 0 sysclk, 1 /4, 2 /12, 3 /48, 4 osc/8, 5 pin |
| ext_pin_i | input | 1 | Asynchronous external count input |
| ext_osc_i | input | 1 | Asynchronous oscillator input |
| rxd_i | input | 1 | Asynchronous receive line (idle high) |
| rx_idle_i | input | 1 | High while the receiver waits for a start bit |
| tx_tick_o | output | 1 | Transmit baud tick, one cycle wide |
| rx_tick_o | output | 1 | Receive baud tick, one cycle wide |

## Verification
The hardest situation to reach is a resynchronisation whose effect can be told apart from ordinary counting. After reset the two channels run in lockstep, so a forced reload only shows if it lands at a phase that differs from the running one. The stimulus waits for a transmit tick and then drops the receive line a fixed few cycles later. The scoreboard queues the exact cycles of the next receive ticks, and the transmit spacing is checked across the same window. The same method is repeated at a second offset, and once more with the receiver marked busy to show that the edge is then ignored.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

    localparam int CNT_W       = 8;
    localparam int SYNC_STAGES = 2;
    localparam int OSC_DIV     = 8;
    localparam int N_PRESC     = 3;
    localparam int N_CHAN      = 2;
    localparam int CH_TX       = 0;
    localparam int CH_RX       = 1;

    typedef logic [CNT_W-1:0] count_t;

    typedef enum logic [2:0] {
        SRC_SYS   = 3'd0,
        SRC_DIV4  = 3'd1,
        SRC_DIV12 = 3'd2,
        SRC_DIV48 = 3'd3,
        SRC_OSC8  = 3'd4,
        SRC_PIN   = 3'd5
    } tick_src_e;

    typedef struct packed {
        count_t cnt;
        logic   half;
    } chan_state_t;

    function automatic int presc_div(input int idx);
        case (idx)
            0:       return 4;
            1:       return 12;
            default: return 48;
        endcase
    endfunction

    function automatic logic at_terminal(input count_t c);
        return &c;
    endfunction

endpackage

// File: rtl/bg_sync_edge.sv
module bg_sync_edge #(
    parameter int STAGES  = 2,
    parameter bit FALLING = 1'b0,
    parameter bit IDLE    = 1'b0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic din_i,
    output logic pulse_o
);

    logic [STAGES:0] sh_q;
    logic            synced;
    logic            prev;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sh_q <= {(STAGES+1){IDLE}};
        end else begin
            sh_q <= {sh_q[STAGES-1:0], din_i};
        end
    end

    assign synced = sh_q[STAGES-1];
    assign prev   = sh_q[STAGES];

    generate
        if (FALLING) begin : g_fall
            assign pulse_o = prev & ~synced;
        end else begin : g_rise
            assign pulse_o = synced & ~prev;
        end
    endgenerate

    // R3 / R6: one edge on the line yields a single-cycle pulse
    a_r3_edge_single: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/bg_prescaler.sv
module bg_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic step_i,
    output logic pulse_o
);

    localparam int             W    = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0]   LAST = W'(DIV - 1);

    logic [W-1:0] cnt_q;
    logic         wrap;

    assign wrap    = (cnt_q == LAST);
    assign pulse_o = step_i & wrap;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    generate
        if (DIV > 1) begin : g_chk
            // R5 / R7: a divided tick never repeats on the next cycle
            a_r5_presc_spaced: assert property (@(posedge clk_i) disable iff (rst_i)
                pulse_o |=> !pulse_o);
        end
    endgenerate

endmodule

// File: rtl/bg_tick_select.sv
module bg_tick_select
    import baud_gen_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  tick_src_e src_i,
    input  logic      ext_pin_i,
    input  logic      ext_osc_i,
    output logic      tick_o
);

    logic [N_PRESC-1:0] presc_pulse;
    logic               osc_edge;
    logic               osc_pulse;
    logic               pin_pulse;

    generate
        for (genvar g = 0; g < N_PRESC; g++) begin : g_presc
            bg_prescaler #(.DIV(presc_div(g))) u_div (
                .clk_i   (clk_i),
                .rst_i   (rst_i),
                .step_i  (1'b1),
                .pulse_o (presc_pulse[g])
            );
        end
    endgenerate

    bg_sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b0), .IDLE(1'b0)) u_osc_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .din_i   (ext_osc_i),
        .pulse_o (osc_edge)
    );

    bg_prescaler #(.DIV(OSC_DIV)) u_osc_div (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .step_i  (osc_edge),
        .pulse_o (osc_pulse)
    );

    bg_sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b0), .IDLE(1'b0)) u_pin_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .din_i   (ext_pin_i),
        .pulse_o (pin_pulse)
    );

    always_comb begin
        case (src_i)
            SRC_SYS:   tick_o = 1'b1;
            SRC_DIV4:  tick_o = presc_pulse[0];
            SRC_DIV12: tick_o = presc_pulse[1];
            SRC_DIV48: tick_o = presc_pulse[2];
            SRC_OSC8:  tick_o = osc_pulse;
            SRC_PIN:   tick_o = pin_pulse;
            default:   tick_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bg_chan_counter.sv
module bg_chan_counter
    import baud_gen_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   en_i,
    input  logic   tick_en_i,
    input  logic   force_i,
    input  count_t reload_i,
    output logic   baud_o
);

    chan_state_t st_q;
    logic        step;
    logic        baud_q;

    assign step   = en_i & tick_en_i;
    assign baud_o = baud_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.cnt  <= reload_i;
            st_q.half <= 1'b0;
            baud_q    <= 1'b0;
        end else begin
            baud_q <= 1'b0;
            if (force_i) begin
                st_q.cnt  <= reload_i;
                st_q.half <= 1'b0;
            end else if (step) begin
                if (at_terminal(st_q.cnt)) begin
                    st_q.cnt  <= reload_i;
                    st_q.half <= ~st_q.half;
                    baud_q    <= st_q.half;
                end else begin
                    st_q.cnt <= st_q.cnt + 1'b1;
                end
            end
        end
    end

    // R1: a wrap loads the reload byte
    a_r1_reload_on_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        (step && at_terminal(st_q.cnt) && !force_i) |=> (st_q.cnt == $past(reload_i)));

    // R3: forced reload restarts the count and clears the divider
    a_r3_forced_reload: assert property (@(posedge clk_i) disable iff (rst_i)
        force_i |=> (st_q.cnt == $past(reload_i)) && !st_q.half && !baud_q);

    // R8: no step, no force: state frozen
    a_r8_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en_i && !force_i) |=> $stable(st_q) && !baud_q);

    // R1: the divider makes ticks at least two cycles apart
    a_r1_tick_spaced: assert property (@(posedge clk_i) disable iff (rst_i)
        baud_q |=> !baud_q);

endmodule

// File: rtl/baud_gen_resync.sv
module baud_gen_resync
    import baud_gen_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       en_i,
    input  logic [7:0] reload_i,
    input  logic [2:0] src_sel_i,
    input  logic       ext_pin_i,
    input  logic       ext_osc_i,
    input  logic       rxd_i,
    input  logic       rx_idle_i,
    output logic       tx_tick_o,
    output logic       rx_tick_o
);

    logic              tick_en;
    logic              start_edge;
    logic              rx_force;
    logic [N_CHAN-1:0] force_vec;
    logic [N_CHAN-1:0] baud_vec;
    logic              resynced_q;

    bg_tick_select u_sel (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .src_i     (tick_src_e'(src_sel_i)),
        .ext_pin_i (ext_pin_i),
        .ext_osc_i (ext_osc_i),
        .tick_o    (tick_en)
    );

    bg_sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b1), .IDLE(1'b1)) u_rx_start (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .din_i   (rxd_i),
        .pulse_o (start_edge)
    );

    assign rx_force = start_edge & rx_idle_i;

    always_comb begin
        force_vec        = '0;
        force_vec[CH_RX] = rx_force;
    end

    generate
        for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
            bg_chan_counter u_cnt (
                .clk_i     (clk_i),
                .rst_i     (rst_i),
                .en_i      (en_i),
                .tick_en_i (tick_en),
                .force_i   (force_vec[c]),
                .reload_i  (count_t'(reload_i)),
                .baud_o    (baud_vec[c])
            );
        end
    endgenerate

    assign tx_tick_o = baud_vec[CH_TX];
    assign rx_tick_o = baud_vec[CH_RX];

    // tracks whether the receive channel has ever been realigned
    always_ff @(posedge clk_i) begin
        if (rst_i)         resynced_q <= 1'b0;
        else if (rx_force) resynced_q <= 1'b1;
    end

    // R10 / R9: without a resync the two channels stay in lockstep
    a_r10_lockstep: assert property (@(posedge clk_i) disable iff (rst_i)
        !resynced_q |-> (rx_tick_o == tx_tick_o));

    // R9: a busy receiver never triggers a resync
    a_r9_busy_ignored: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rx_idle_i && !resynced_q) |=> !resynced_q);

endmodule

// File: tb/tb_baud_gen_resync.sv
module tb_baud_gen_resync;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b1;
    logic [7:0] reload = 8'hF0;
    logic [2:0] src = 3'd0;
    logic       ext_pin = 1'b0;
    logic       ext_osc = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_idle = 1'b1;
    logic       tx_tick;
    logic       rx_tick;

    always #5 clk = ~clk;

    baud_gen_resync dut (
        .clk_i     (clk),
        .rst_i     (rst),
        .en_i      (en),
        .reload_i  (reload),
        .src_sel_i (src),
        .ext_pin_i (ext_pin),
        .ext_osc_i (ext_osc),
        .rxd_i     (rxd),
        .rx_idle_i (rx_idle),
        .tx_tick_o (tx_tick),
        .rx_tick_o (rx_tick)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // external stimulus generators
    bit pin_run = 0;
    bit osc_run = 0;
    int pin_ph  = 0;
    int osc_ph  = 0;
    always @(negedge clk) begin
        if (pin_run) begin pin_ph = (pin_ph + 1) % 6; ext_pin = (pin_ph < 3); end
        else ext_pin = 1'b0;
        if (osc_run) begin osc_ph = (osc_ph + 1) % 4; ext_osc = (osc_ph < 2); end
        else ext_osc = 1'b0;
    end

    // monitor / scoreboard
    bit    tx_per_chk = 0;
    bit    tx_seen    = 0;
    int    tx_per_exp = 0;
    int    last_tx    = 0;
    int    tx_count   = 0;
    string tx_tag     = "R1";
    int    rx_q[$];
    bit    rx_chk_on  = 0;
    string rx_tag     = "R3";

    always @(negedge clk) begin : mon
        int e;
        if (!rst && tx_tick) begin
            if (tx_per_chk && tx_seen)
                chk(cyc - last_tx == tx_per_exp, tx_tag, cyc - last_tx, tx_per_exp);
            tx_seen  = 1;
            last_tx  = cyc;
            tx_count = tx_count + 1;
        end
        if (rx_chk_on) begin
            if (rx_tick) begin
                if (rx_q.size() == 0) chk(0, rx_tag, cyc, -1);
                else begin
                    e = rx_q.pop_front();
                    chk(cyc == e, rx_tag, cyc, e);
                end
            end else if (rx_q.size() > 0 && cyc > rx_q[0]) begin
                chk(0, rx_tag, cyc, rx_q[0]);
                void'(rx_q.pop_front());
            end
        end
    end

    task automatic do_reset(input logic [7:0] r, input logic [2:0] s);
        @(negedge clk);
        rst = 1'b1; reload = r; src = s; tx_per_chk = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0; tx_seen = 0;
    endtask

    task automatic run_period(input logic [7:0] r, input logic [2:0] s,
                              input int per, input string tag, input int n);
        int t;
        do_reset(r, s);
        tx_tag = tag; tx_per_exp = per; tx_per_chk = 1;
        t = tx_count + n + 1;
        wait (tx_count >= t);
        tx_per_chk = 0;
    endtask

    task automatic resync_at(input int offset, input string tag);
        int t;
        int k;
        t = tx_count;
        wait (tx_count > t);
        repeat (offset) @(negedge clk);
        k = cyc;
        rxd = 1'b0;
        rx_q.push_back(k + 35);
        rx_q.push_back(k + 67);
        rx_q.push_back(k + 99);
        rx_tag = tag;
        rx_chk_on = 1;
        while (rx_q.size() > 0) @(negedge clk);
        rx_chk_on = 0;
        rxd = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    initial begin : main
        int c;
        int t;
        int tt;
        int mism;
        int rxn;

        // R10: reset state and aligned first ticks
        repeat (3) begin
            @(negedge clk);
            chk(!tx_tick && !rx_tick, "R10 reset low", {tx_tick, rx_tick}, 0);
        end
        rst = 1'b0; c = cyc;
        while (!tx_tick) @(negedge clk);
        chk(cyc == c + 32, "R10 first tick", cyc - c, 32);
        chk(rx_tick == 1'b1, "R10 rx aligned", rx_tick, 1);

        // R1 / R2
        run_period(8'hF0, 3'd0, 32,  "R1", 4);
        run_period(8'hA5, 3'd0, 182, "R1", 3);
        run_period(8'hFF, 3'd0, 2,   "R2", 5);
        run_period(8'h00, 3'd0, 512, "R2", 2);

        // R5 prescaled sources
        run_period(8'hF0, 3'd1, 128, "R5 div4", 3);
        run_period(8'hF8, 3'd2, 192, "R5 div12", 3);
        run_period(8'hFC, 3'd3, 384, "R5 div48", 3);

        // R6 external pin
        pin_run = 1;
        run_period(8'hFE, 3'd5, 24, "R6", 4);
        pin_run = 0;

        // R7 oscillator input /8
        osc_run = 1;
        run_period(8'hFF, 3'd4, 64, "R7", 4);
        osc_run = 0;

        // R8 enable hold
        do_reset(8'hF0, 3'd0);
        t = tx_count;
        wait (tx_count > t);
        c = last_tx;
        repeat (5) @(negedge clk);
        en = 1'b0;
        t = tx_count;
        repeat (50) @(negedge clk);
        chk(tx_count == t, "R8 no tick while disabled", tx_count - t, 0);
        en = 1'b1;
        wait (tx_count > t);
        chk(last_tx == c + 82, "R8 delayed tick", last_tx - c, 82);
        chk(rx_tick == 1'b1, "R8 rx held", rx_tick, 1);

        // R3 / R4 resync at two offsets, tx spacing checked throughout
        do_reset(8'hF0, 3'd0);
        tx_tag = "R4"; tx_per_exp = 32; tx_per_chk = 1;
        resync_at(7, "R3 offset7");
        resync_at(13, "R3 offset13");
        tx_per_chk = 0;

        // R9 busy receiver ignores the edge
        do_reset(8'hF0, 3'd0);
        rx_idle = 1'b0;
        repeat (20) @(negedge clk);
        rxd = 1'b0;
        mism = 0; rxn = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (tx_tick != rx_tick) mism++;
            if (rx_tick) rxn++;
        end
        chk(mism == 0, "R9 lockstep kept", mism, 0);
        chk(rxn >= 6, "R9 rx still ticking", rxn, 6);
        rxd = 1'b1; rx_idle = 1'b1;
        tt = 0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule